// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block sits in the read path of a flash memory that can deliver data in bursts. A host presents a start word address on a shared address/data bus and pulses an address-valid strobe. The sequencer takes that address on a clock edge, holds its ready flag low for a set number of clock cycles while the array warms up, and then supplies a new word address on every following clock edge. The array read logic (not part of this block) uses that address to fetch data, and the host uses the ready flag to know which cycles carry valid data.

Bursts can be fixed-length blocks of 8, 16 or 32 words or open-ended. A fixed-length block either stays inside its aligned block and wraps round within it, or runs straight on through memory and stops after the set number of words. So one start address can give two different address sequences. The open-ended mode counts up without limit and rolls over from the top address to zero. Dropping chip enable ends a burst at once.

The control is a four-state machine. ST_IDLE is the state after reset or after chip enable is dropped. ST_WAIT counts the initial latency. ST_STREAM supplies one address per clock. ST_DONE is where a no-wrap burst rests after its last word. Transitions: a capture (chip enable low and strobe low at a clock edge) moves any state to ST_WAIT. In ST_WAIT, when the latency count runs out, the machine moves to ST_STREAM. In ST_STREAM, once the last word of a no-wrap burst has been supplied, it moves to ST_DONE. Chip enable high at an edge moves any state to ST_IDLE. Capture and chip-enable checks take priority over the per-state transitions.

Top module: `burst_addr_seq`

## Requirements
- R1: At a rising clock edge with `ce_n` low and `avd_n` low, the value on `addr_in` is captured and appears on `addr_out` after that edge, with `rdy` low. This applies in any state, so a capture during a burst restarts it.
- R2: While `avd_n` is high, `addr_in` has no effect: `addr_out` follows only the burst sequence, whatever is on the bus.
- R3: After a capture, `rdy` stays low for L clock edges, where L is the `latency` input sampled at the capture edge. A value of 0 counts as 1. `rdy` rises after the L-th edge and the first word address is then the start address.
- R4: In continuous mode (`burst_mode` 3'b000 or 3'b100), each edge during which `rdy` is high advances `addr_out` by one. The count rolls over from all-ones to zero and never stops.
- R5: In wrap modes (`burst_mode` 3'b001, 3'b010, 3'b011 give N = 8, 16, 32), the low log2(N) bits of the address count modulo N and the upper bits stay those of the start address. The burst runs until it is ended.
- R6: In no-wrap modes (`burst_mode` 3'b101, 3'b110, 3'b111 give N = 8, 16, 32), the whole address increments by one per word. `rdy` is high for exactly N cycles and then drops, with `addr_out` held at start+N-1.
- R7: `ce_n` high forces `rdy` low at once, without waiting for a clock edge. Any edge with `ce_n` high returns the sequencer to idle, even with `avd_n` low, and `addr_out` is then not loaded.
- R8: While `rst_n` is low, the sequencer is idle with `rdy` low and `addr_out` zero.
- R9: The burst mode is taken from `burst_mode` at the capture edge. Bit 2 selects no-wrap and bits 1:0 select the length: 0 means continuous, 1 means 8, 2 means 16 and 3 means 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| avd_n | input | 1 | Active-low address-valid strobe |
| addr_in | input | ADDR_W | Start word address from the multiplexed bus |
| burst_mode | input | 3 | Burst mode setting (see R9) |
| latency | input | LAT_W | Initial latency in clock cycles |
| addr_out | output | ADDR_W | Current word address for the array |
| rdy | output | 1 | High when the current word is valid |

## Verification
The step assertions read `burst_mode` from the port, not from the captured copy. They therefore assume the mode input stays steady for the whole burst. Every burst in the stimulus drives the mode once, at capture, and leaves it unchanged until chip enable rises. The stimulus drives the inputs only on falling edges, so the checker never sees a strobe change between clock edges. The bench runs a sweep over every mode code, a set of start addresses placed near block and address-space edges, and latencies of zero and above, on an 8-bit address configuration so that the top-of-space rollover is reached.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_STREAM,
        ST_DONE
    } seq_state_t;

    localparam int WCNT_W = 5;

    // bits of the address that cycle inside a wrap block
    function automatic int blk_bits(input logic [1:0] code);
        case (code)
            2'd1:    return 3;
            2'd2:    return 4;
            2'd3:    return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [WCNT_W-1:0] words_minus_one(input logic [1:0] code);
        case (code)
            2'd1:    return WCNT_W'(7);
            2'd2:    return WCNT_W'(15);
            2'd3:    return WCNT_W'(31);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bseq_tally.sv
module bseq_tally #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && count != '0) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/bseq_addr_step.sv
module bseq_addr_step
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [2:0]        mode,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] sum;
    logic              wrap_en;
    int                nbits;

    assign sum     = cur + 1'b1;
    assign wrap_en = !mode[2] && (mode[1:0] != 2'd0);
    assign nbits   = blk_bits(mode[1:0]);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign nxt[i] = (wrap_en && i >= nbits) ? cur[i] : sum[i];
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              avd_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [2:0]        burst_mode,
    input  logic [LAT_W-1:0]  latency,
    output logic [ADDR_W-1:0] addr_out,
    output logic              rdy
);
    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_nxt;
    logic [2:0]        mode_q;
    logic              capture;
    logic [LAT_W-1:0]  lat_load, lat_cnt;
    logic [WCNT_W-1:0] word_cnt;
    logic              last_word;

    assign capture   = !ce_n && !avd_n;
    assign lat_load  = (latency == '0) ? LAT_W'(1) : latency;
    assign last_word = mode_q[2] && (mode_q[1:0] != 2'd0) && (word_cnt == '0);

    bseq_tally #(.W(LAT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (capture),
        .load_val (lat_load),
        .dec      (state_q == ST_WAIT),
        .count    (lat_cnt)
    );

    bseq_tally #(.W(WCNT_W)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (capture),
        .load_val (words_minus_one(burst_mode[1:0])),
        .dec      (state_q == ST_STREAM),
        .count    (word_cnt)
    );

    bseq_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur  (addr_q),
        .mode (mode_q),
        .nxt  (addr_nxt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ce_n) begin
            state_d = ST_IDLE;
        end else if (!avd_n) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_WAIT:   state_d = (lat_cnt <= LAT_W'(1)) ? ST_STREAM : ST_WAIT;
                ST_STREAM: state_d = last_word ? ST_DONE : ST_STREAM;
                ST_DONE:   state_d = ST_DONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // address and captured mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mode_q <= 3'b000;
        end else if (capture) begin
            addr_q <= addr_in;
            mode_q <= burst_mode;
        end else if (state_q == ST_STREAM && state_d == ST_STREAM) begin
            addr_q <= addr_nxt;
        end
    end

    // outputs
    always_comb begin
        addr_out = addr_q;
        rdy      = (state_q == ST_STREAM) && !ce_n;
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int LAT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              avd_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [2:0]        burst_mode,
    input logic [ADDR_W-1:0] addr_out,
    input logic              rdy
);
    logic              wrap_mode;
    logic [ADDR_W-1:0] blk_mask;

    assign wrap_mode = !burst_mode[2] && (burst_mode[1:0] != 2'd0);
    assign blk_mask  = (ADDR_W'(1) << blk_bits(burst_mode[1:0])) - 1'b1;

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !avd_n) |=> (addr_out == $past(addr_in)) && !rdy); // R1

    AST_CE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !rdy); // R7

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && $past(rdy) && !wrap_mode) |-> addr_out == $past(addr_out) + 1'b1); // R4

    AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && $past(rdy) && wrap_mode) |->
            ((addr_out & ~blk_mask) == ($past(addr_out) & ~blk_mask)) &&
            ((addr_out & blk_mask) == (($past(addr_out) + 1'b1) & blk_mask))); // R5
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .avd_n      (avd_n),
    .addr_in    (addr_in),
    .burst_mode (burst_mode),
    .addr_out   (addr_out),
    .rdy        (rdy)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int AW = 8;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          avd_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [2:0]    burst_mode = 3'b000;
    logic [LW-1:0] latency = '0;
    logic [AW-1:0] addr_out;
    logic          rdy;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .LAT_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .avd_n(avd_n),
        .addr_in(addr_in), .burst_mode(burst_mode), .latency(latency),
        .addr_out(addr_out), .rdy(rdy)
    );

    task automatic check(input string req, input logic [AW:0] act, input logic [AW:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [2:0] m, input logic [AW-1:0] s, input int j);
        logic [AW-1:0] lin;
        logic [AW-1:0] msk;
        lin = s + AW'(j);
        if (!m[2] && m[1:0] != 2'd0) begin
            msk = AW'((8 << (m[1:0] - 1)) - 1);
            return (s & ~msk) | (lin & msk);
        end
        return lin;
    endfunction

    task automatic burst(input logic [2:0] m, input logic [AW-1:0] s, input int lat);
        int leff;
        int n;
        bit nowrap;
        leff   = (lat == 0) ? 1 : lat;
        nowrap = m[2] && (m[1:0] != 2'd0);
        n      = (m[1:0] == 2'd0) ? 0 : (8 << (m[1:0] - 1));
        @(negedge clk);
        ce_n = 0; avd_n = 0; addr_in = s; burst_mode = m; latency = LW'(lat);
        @(negedge clk);
        check("R1 addr", {1'b0, addr_out}, {1'b0, s});
        check("R1 rdy", {AW'(0), rdy}, '0);
        avd_n = 1; addr_in = ~s;                       // R2 junk on bus
        for (int k = 1; k < leff; k++) begin
            @(negedge clk);
            check("R3 latency", {AW'(0), rdy}, '0);
            addr_in = addr_in + 8'h33;
        end
        for (int j = 0; j < (nowrap ? n + 1 : 40); j++) begin
            @(negedge clk);
            if (nowrap && j == n) begin
                check("R6 end rdy", {AW'(0), rdy}, '0);
                check("R6 hold", {1'b0, addr_out}, {1'b0, AW'(s + AW'(n - 1))});
            end else begin
                check(nowrap ? "R6 step" : (n == 0 ? "R4 step" : "R5 step"),
                      {rdy, addr_out}, {1'b1, exp_addr(m, s, j)});
            end
            addr_in = addr_in ^ 8'h5A;                 // R2 bus noise
        end
        ce_n = 1;
        #1 check("R7 async", {AW'(0), rdy}, '0);
        @(negedge clk);
        check("R7 idle", {AW'(0), rdy}, '0);
    endtask

    initial begin
        logic [AW-1:0] starts [5];
        logic [AW-1:0] held;
        starts = '{8'h00, 8'h05, 8'h1B, 8'h3F, 8'hF7};
        repeat (3) @(negedge clk);
        check("R8 rdy", {AW'(0), rdy}, '0);
        check("R8 addr", {1'b0, addr_out}, '0);
        rst_n = 1;
        // R9 sweep over every mode code
        for (int m = 0; m < 8; m++)
            for (int si = 0; si < 5; si++)
                for (int l = 0; l < 4; l += 2)
                    burst(3'(m), starts[si], l);
        burst(3'b000, 8'hFC, 3);                       // R4 rollover at top
        burst(3'b011, 8'hE3, 5);                       // R5 32-word block
        // R7: strobe with chip enable high does not load
        held = addr_out;
        @(negedge clk); ce_n = 1; avd_n = 0; addr_in = ~held;
        @(negedge clk);
        check("R7 no load", {1'b0, addr_out}, {1'b0, held});
        check("R7 no rdy", {AW'(0), rdy}, '0);
        avd_n = 1;
        // R1 restart during a stream
        @(negedge clk); ce_n = 0; avd_n = 0; addr_in = 8'h40; burst_mode = 3'b000; latency = 1;
        @(negedge clk); avd_n = 1;
        repeat (3) @(negedge clk);
        avd_n = 0; addr_in = 8'h90;
        @(negedge clk); avd_n = 1;
        check("R1 restart", {rdy, addr_out}, {1'b0, 8'h90});
        @(negedge clk);
        check("R1 restart stream", {rdy, addr_out}, {1'b1, 8'h90});
        // R8 reset mid-stream
        rst_n = 0;
        #1 check("R8 mid", {rdy, addr_out}, '0);
        ce_n = 1;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule